// File: doc/BRIEF.md
# Three-Word Jump Sequencer

This block carries out a direct-address jump whose encoding occupies three consecutive 10-bit program words. The surrounding decoder hands over the first word together with its address and a one-cycle start strobe. If that word carries the jump opcode, the sequencer reads the two following words over a request/valid memory port. The port waits as long as needed for each word.

From the second and third words it forms a 16-bit target. The second word's top two bits name a return register. Its middle six bits are the upper target bits. Its bottom two bits ask for an interrupt-enable change. All ten bits of the third word are the lower target bits.

In a single commit cycle the sequencer loads the program counter and raises a done pulse. In the same cycle it may write the return address to a general register. The interrupt-enable flag it owns is updated at the end of that cycle.

Top module: `jump_seq`

## Requirements
- R1: After reset the block is idle: busy, fetch_req, pc_load, rf_we and done are 0, and ie is 0.
- R2: A start strobe is accepted only when the block is idle and first_word equals 10'b0000000100. Otherwise it is ignored, and fetch_req and busy stay 0 in the next cycle.
- R3: In the cycle after an accepted start, fetch_req is 1 with fetch_addr = start_pc+1. After that word is delivered, fetch_addr = start_pc+2. Addresses wrap modulo 2^16.
- R4: In the cycle after the third word is delivered, pc_load and done are 1 for exactly one cycle. In that cycle pc_value = {w2[7:2], w3[9:0]}.
- R5: Bits 9..8 of the second word select the return register: 00 gives rf_sel 4, 01 gives 5, 10 gives 6. For these codes rf_we is 1 in the pc_load cycle with rf_wdata = start_pc+3. The code 11 is a plain jump, and rf_we stays 0.
- R6: Bits 1..0 of the second word control interrupts: 01 sets ie and 10 clears it. Codes 00 and 11 leave it unchanged. The new value is visible in the cycle after done.
- R7: A start strobe that arrives while busy is ignored: the fetch addresses and the saved return address still come from the jump in progress.
- R8: done, pc_load and rf_we are 0 in every cycle other than the commit cycle.
- R9: While fetch_valid is low, fetch_req stays 1 and fetch_addr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Strobe: first word is ready for inspection |
| first_word | input | 10 | First instruction word |
| start_pc | input | 16 | Address of the first instruction word |
| busy | output | 1 | A jump is in progress |
| fetch_req | output | 1 | Read request for an operand word |
| fetch_addr | output | 16 | Address of the requested word |
| fetch_valid | input | 1 | Read data is valid this cycle |
| fetch_data | input | 10 | Read data |
| rf_we | output | 1 | Return-register write enable |
| rf_sel | output | 3 | Return-register index (4, 5 or 6) |
| rf_wdata | output | 16 | Return address |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 16 | Jump target |
| ie | output | 1 | Interrupt-enable flag |
| done | output | 1 | Jump completed this cycle |

## Verification
The assertions assume that fetch_valid is asserted only while fetch_req is high. They also assume that the memory answers each request with exactly one valid cycle. The stimulus keeps to this by driving fetch_valid only inside the fetch phases it has observed, always for a single cycle, and after a chosen number of wait cycles. Start strobes are raised both while idle and while busy. This way the assertions that tie interrupt changes to done, and register writes to pc_load, see both accepted and ignored requests.

// File: rtl/jseq_pkg.sv
// Shared constants and types for the three-word jump sequencer.
// Assumes 10-bit program words. The target width follows from the word width.
package jseq_pkg;
    localparam int WORD_W_DEF = 10;
    localparam int RSEL_W_DEF = 3;
    localparam int REG_BASE_DEF = 4;
    localparam logic [WORD_W_DEF-1:0] JUMP_OP_DEF = 10'b0000000100;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_W2     = 2'd1,
        ST_W3     = 2'd2,
        ST_COMMIT = 2'd3
    } seq_state_t;

    localparam logic [1:0] IE_SET = 2'b01;
    localparam logic [1:0] IE_CLR = 2'b10;
    localparam logic [1:0] NO_SAVE = 2'b11;
endpackage

// File: rtl/jseq_ctrl.sv
// Sequencing state machine: idle, fetch word 2, fetch word 3, commit.
// Assumes the memory port delivers one valid beat per request.
module jseq_ctrl #(
    parameter int WORD_W = jseq_pkg::WORD_W_DEF,
    parameter logic [WORD_W-1:0] JUMP_OP = jseq_pkg::JUMP_OP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] first_word,
    input  logic              fetch_valid,
    output logic              accept,
    output logic              in_w2,
    output logic              in_w3,
    output logic              commit
);
    import jseq_pkg::*;

    seq_state_t state_q, state_d;

    // Decode the current state into phase flags.
    always_comb begin
        in_w2  = (state_q == ST_W2);
        in_w3  = (state_q == ST_W3);
        commit = (state_q == ST_COMMIT);
        accept = (state_q == ST_IDLE) && start && (first_word == JUMP_OP);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (accept) state_d = ST_W2;
            ST_W2:     if (fetch_valid) state_d = ST_W3;
            ST_W3:     if (fetch_valid) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/jseq_decode.sv
// Field split of the two operand words into target, return register and
// interrupt request. Purely combinational. Assumes WORD_W >= 5.
module jseq_decode #(
    parameter int WORD_W = jseq_pkg::WORD_W_DEF,
    parameter int RSEL_W = jseq_pkg::RSEL_W_DEF,
    parameter int REG_BASE = jseq_pkg::REG_BASE_DEF,
    localparam int HI_W = WORD_W - 4,
    localparam int ADDR_W = HI_W + WORD_W
) (
    input  logic [WORD_W-1:0] w2,
    input  logic [WORD_W-1:0] w3,
    output logic [ADDR_W-1:0] target,
    output logic              save_ret,
    output logic [RSEL_W-1:0] ret_sel,
    output logic              ie_set,
    output logic              ie_clr
);
    import jseq_pkg::*;

    logic [1:0]      xx;
    logic [HI_W-1:0] hi;
    logic [1:0]      yy;

    // Split the second word into its three fields.
    always_comb begin
        xx = w2[WORD_W-1 -: 2];
        hi = w2[WORD_W-3 -: HI_W];
        yy = w2[1:0];
    end

    // Build the target and the side-effect requests.
    always_comb begin
        target   = {hi, w3};
        save_ret = (xx != NO_SAVE);
        ret_sel  = RSEL_W'(REG_BASE) + RSEL_W'(xx);
        ie_set   = (yy == IE_SET);
        ie_clr   = (yy == IE_CLR);
    end
endmodule

// File: rtl/jseq_ie.sv
// Interrupt-enable flag, updated only by a committing jump.
// Assumes set and clear are never requested together.
module jseq_ie (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic ie_set,
    input  logic ie_clr,
    output logic ie
);
    // Hold, set or clear the flag at the commit edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ie <= 1'b0;
        else if (commit && ie_set)  ie <= 1'b1;
        else if (commit && ie_clr)  ie <= 1'b0;
    end
endmodule

// File: rtl/jump_seq.sv
// Top of the three-word jump sequencer. Fetches the two operand words after
// a recognised jump opcode, then loads the PC. In the same cycle it
// optionally writes the return address and requests an interrupt-enable change.
// Assumes fetch_valid comes only while fetch_req is high.
module jump_seq #(
    parameter int WORD_W = jseq_pkg::WORD_W_DEF,
    parameter int RSEL_W = jseq_pkg::RSEL_W_DEF,
    parameter int REG_BASE = jseq_pkg::REG_BASE_DEF,
    parameter logic [WORD_W-1:0] JUMP_OP = jseq_pkg::JUMP_OP_DEF,
    localparam int ADDR_W = 2 * WORD_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] first_word,
    input  logic [ADDR_W-1:0] start_pc,
    output logic              busy,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_data,
    output logic              rf_we,
    output logic [RSEL_W-1:0] rf_sel,
    output logic [ADDR_W-1:0] rf_wdata,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              ie,
    output logic              done
);
    localparam int INSTR_LEN = 3;

    logic              accept, in_w2, in_w3, commit;
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] w2_q, w3_q;
    logic [ADDR_W-1:0] target;
    logic              save_ret, ie_set, ie_clr;
    logic [RSEL_W-1:0] ret_sel;

    jseq_ctrl #(.WORD_W(WORD_W), .JUMP_OP(JUMP_OP)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .first_word(first_word),
        .fetch_valid(fetch_valid), .accept(accept), .in_w2(in_w2),
        .in_w3(in_w3), .commit(commit)
    );

    jseq_decode #(.WORD_W(WORD_W), .RSEL_W(RSEL_W), .REG_BASE(REG_BASE)) u_dec (
        .w2(w2_q), .w3(w3_q), .target(target), .save_ret(save_ret),
        .ret_sel(ret_sel), .ie_set(ie_set), .ie_clr(ie_clr)
    );

    jseq_ie u_ie (
        .clk(clk), .rst_n(rst_n), .commit(commit), .ie_set(ie_set),
        .ie_clr(ie_clr), .ie(ie)
    );

    // Capture the instruction address and both operand words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            w2_q   <= '0;
            w3_q   <= '0;
        end else begin
            if (accept)               base_q <= start_pc;
            if (in_w2 && fetch_valid) w2_q   <= fetch_data;
            if (in_w3 && fetch_valid) w3_q   <= fetch_data;
        end
    end

    // Drive the fetch port and the commit-cycle outputs.
    always_comb begin
        busy       = in_w2 | in_w3 | commit;
        fetch_req  = in_w2 | in_w3;
        fetch_addr = base_q + (in_w3 ? ADDR_W'(2) : ADDR_W'(1));
        pc_load    = commit;
        done       = commit;
        pc_value   = target;
        rf_we      = commit & save_ret;
        rf_sel     = ret_sel;
        rf_wdata   = base_q + ADDR_W'(INSTR_LEN);
    end
endmodule

// File: rtl/jump_seq_chk.sv
// Property checker for jump_seq, attached by bind. Observes ports only.
module jump_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int RSEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_valid,
    input logic              rf_we,
    input logic [RSEL_W-1:0] rf_sel,
    input logic              pc_load,
    input logic              ie,
    input logic              done
);
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_valid) |=> (fetch_req && $stable(fetch_addr)));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_write_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> pc_load);

    a_r5_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_sel >= RSEL_W'(4) && rf_sel <= RSEL_W'(6)));

    a_r6_ie_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ie != $past(ie)) |-> $past(done));

    a_r3_req_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> fetch_req);

    a_r8_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (busy && !done));
endmodule

bind jump_seq jump_seq_chk #(.ADDR_W(ADDR_W), .RSEL_W(RSEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .rf_we(rf_we),
    .rf_sel(rf_sel), .pc_load(pc_load), .ie(ie), .done(done)
);

// File: tb/tb_jump_seq.sv
// Directed bench for jump_seq: one task per scenario, each checking itself.
module tb_jump_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] OPC = 10'b0000000100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  first_word = '0;
    logic [15:0] start_pc = '0;
    logic        busy, fetch_req, fetch_valid = 1'b0;
    logic [15:0] fetch_addr;
    logic [9:0]  fetch_data = '0;
    logic        rf_we, pc_load, ie, done;
    logic [2:0]  rf_sel;
    logic [15:0] rf_wdata, pc_value;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit ie_model = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jump_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .first_word(first_word),
        .start_pc(start_pc), .busy(busy), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .rf_we(rf_we), .rf_sel(rf_sel),
        .rf_wdata(rf_wdata), .pc_load(pc_load), .pc_value(pc_value),
        .ie(ie), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R1: state straight after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "fetch_req", fetch_req, 0);
        chk("R1", "pc_load", pc_load, 0);
        chk("R1", "rf_we", rf_we, 0);
        chk("R1", "done", done, 0);
        chk("R1", "ie", ie, 0);
        ie_model = 0;
    endtask

    // R2: wrong opcode is ignored
    task automatic t_bad_opcode(input logic [9:0] w);
        start = 1'b1; first_word = w; start_pc = 16'h1234;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "fetch_req after bad opcode", fetch_req, 0);
        chk("R2", "busy after bad opcode", busy, 0);
        @(negedge clk);
        chk("R2", "still idle", busy, 0);
    endtask

    // R3..R9: one complete jump with optional wait states and a busy start poke
    task automatic t_jump(input logic [15:0] pc, input logic [9:0] w2, input logic [9:0] w3,
                          input int wait2, input int wait3, input bit poke);
        logic [15:0] exp_tgt;
        logic [1:0]  xx, yy;
        exp_tgt = {w2[7:2], w3};
        xx = w2[9:8];
        yy = w2[1:0];
        start = 1'b1; first_word = OPC; start_pc = pc;
        @(negedge clk);
        start = 1'b0;
        chk("R3", "fetch_req word2", fetch_req, 1);
        chk("R3", "addr word2", fetch_addr, 16'(pc + 16'd1));
        for (int i = 0; i < wait2; i++) begin
            if (poke && i == 0) begin
                start = 1'b1; first_word = OPC; start_pc = 16'h0F0F;
            end
            @(negedge clk);
            start = 1'b0;
            chk("R9", "req held word2", fetch_req, 1);
            chk(poke ? "R7" : "R9", "addr held word2", fetch_addr, 16'(pc + 16'd1));
            chk("R8", "no done while fetching", done, 0);
        end
        fetch_valid = 1'b1; fetch_data = w2;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk("R3", "addr word3", fetch_addr, 16'(pc + 16'd2));
        chk("R8", "no pc_load in word3 phase", pc_load, 0);
        for (int i = 0; i < wait3; i++) begin
            @(negedge clk);
            chk("R9", "addr held word3", fetch_addr, 16'(pc + 16'd2));
        end
        fetch_valid = 1'b1; fetch_data = w3;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk("R4", "done", done, 1);
        chk("R4", "pc_load", pc_load, 1);
        chk("R4", "pc_value", pc_value, exp_tgt);
        chk("R5", "rf_we", rf_we, (xx != 2'b11) ? 1 : 0);
        if (xx != 2'b11) begin
            chk("R5", "rf_sel", rf_sel, 4 + xx);
            chk(poke ? "R7" : "R5", "rf_wdata", rf_wdata, 16'(pc + 16'd3));
        end
        chk("R6", "ie not yet changed", ie, ie_model);
        if (yy == 2'b01) ie_model = 1;
        else if (yy == 2'b10) ie_model = 0;
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
        chk("R8", "rf_we idle", rf_we, 0);
        chk("R6", "ie after jump", ie, ie_model);
        chk("R8", "busy cleared", busy, 0);
    endtask

    initial begin
        t_reset();
        t_bad_opcode(10'h005);
        t_bad_opcode(10'h204);
        t_jump(16'h0100, {2'b00, 6'h2A, 2'b01}, 10'h155, 0, 0, 0);
        t_jump(16'h2000, {2'b01, 6'h15, 2'b00}, 10'h2AA, 2, 3, 0);
        t_jump(16'h3333, {2'b10, 6'h01, 2'b10}, 10'h001, 1, 0, 1);
        t_jump(16'h4000, {2'b11, 6'h3F, 2'b11}, 10'h3FF, 0, 1, 0);
        t_jump(16'hFFFE, {2'b00, 6'h00, 2'b01}, 10'h000, 0, 0, 0);
        t_jump(16'h0010, {2'b11, 6'h20, 2'b11}, 10'h200, 1, 1, 0);
        t_jump(16'h0020, {2'b01, 6'h07, 2'b10}, 10'h0F0, 0, 0, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R3 fetch sequence actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule